// File: doc/BRIEF.md
# PC Card Host Bus Decoder

This block turns the signals of a 16-bit PC Card style host bus into accesses on a card's internal resources. It reads the two active-low card enables, address bit 0, the space select line and the four active-low strobes. From them it chooses one of three targets: attribute memory, common memory or the IO register file. It also works out which byte lanes of the 16-bit data path take part, and moves the host data onto those lanes. Each internal target is a plain read/write port that answers with a ready signal.

A cycle state machine (`pcd_cycle_fsm`) runs every host cycle. Its states are:

- `CYC_IDLE`: no cycle in progress.
- `CYC_ACCESS`: the target request is active and the host is held with the wait output.
- `CYC_DONE`: the target has answered. Read data stays latched and driven until the host releases its strobe.

Its transitions are:

- IDLE to ACCESS on a valid access.
- ACCESS to DONE on target ready.
- ACCESS to IDLE if the access is withdrawn.
- DONE to IDLE when the strobe is released.

A second machine (`pcd_wake`, states `WK_CLEAR` and `WK_SET`) keeps a wake output asserted from an enabled frame reception until the matching receive interrupt is acknowledged. Its transitions are CLEAR to SET on an enabled frame, and SET to CLEAR on the acknowledge.

The block also drives an active-low 16-bit IO indicator. This indicator depends only on the space select and the memory strobes, so it is valid before the host asserts a card enable or an IO command.

Top module: `pccard_decoder`

## Requirements
- R1: With both card enables high, no target select, request or data drive is active, and the wait output stays high.
- R2: Byte mode is enable 1 low with enable 2 high. Data uses host bits 7:0. With address bit 0 = 0, byte enables are 2'b01 and read data comes from target bits 7:0. With address bit 0 = 1, byte enables are 2'b10 and read data comes from target bits 15:8. Write data is the host low byte copied to both halves. The unused host lane reads as zero.
- R3: Word mode is both enables low. Byte enables are 2'b11, data passes straight through on bits 15:0, and address bit 0 is ignored.
- R4: Odd-only mode is enable 1 high with enable 2 low. Byte enables are 2'b10 and data uses host bits 15:8. Write data is the host high byte copied to both halves, the host low lane reads as zero, and address bit 0 is ignored.
- R5: A memory cycle (output enable or write enable low) selects attribute memory when the space select is low, and common memory when it is high.
- R6: An IO cycle (IO read or IO write low) selects the IO registers only when the space select is low; with it high there is no access. The target word address is host address bits ADDR_W-1:1. At most one select is active at a time.
- R7: An access is valid only when exactly one of the four strobes is low; two or more low strobes give no access. An active-high reset returns both state machines to their idle states.
- R8: The 16-bit IO indicator is low whenever the space select is low and neither memory strobe is low, regardless of card enables or IO strobes.
- R9: The wait output goes low in the same cycle a valid access appears. It stays low while the target is not ready, and goes high the clock after the target reports ready.
- R10: Read data is latched when the target reports ready. It is driven on the active lanes, unchanged, until the host releases the strobe; the drive stops on release.
- R11: When wake is enabled, a frame reception drives the wake output low from the next clock. It stays low until the receive interrupt acknowledge. With wake disabled, frames have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| host_ce1_n | input | 1 | Card enable 1, active low (low lane) |
| host_ce2_n | input | 1 | Card enable 2, active low (high lane) |
| host_a | input | ADDR_W | Host address; bit 0 picks the byte in byte mode |
| host_reg_n | input | 1 | Space select: low for attribute space and IO, high for common space |
| host_oe_n | input | 1 | Memory read strobe, active low |
| host_we_n | input | 1 | Memory write strobe, active low |
| host_iord_n | input | 1 | IO read strobe, active low |
| host_iowr_n | input | 1 | IO write strobe, active low |
| host_d_in | input | DATA_W | Write data from the host |
| host_d_out | output | DATA_W | Read data to the host, steered to lanes |
| host_d_oe_lo | output | 1 | Drive enable for host data bits 7:0 |
| host_d_oe_hi | output | 1 | Drive enable for host data bits 15:8 |
| host_io16_n | output | 1 | 16-bit IO indicator, active low |
| host_wait_n | output | 1 | Cycle-extension wait, active low |
| host_wake_n | output | 1 | Wake event, active low |
| tgt_attr_sel | output | 1 | Attribute memory select |
| tgt_comm_sel | output | 1 | Common memory select |
| tgt_io_sel | output | 1 | IO register select |
| tgt_rd | output | 1 | Target read request |
| tgt_wr | output | 1 | Target write request |
| tgt_addr | output | ADDR_W-1 | Target word address |
| tgt_be | output | 2 | Target byte enables, bit 0 for bits 7:0 |
| tgt_wdata | output | DATA_W | Target write data |
| tgt_rdata | input | DATA_W | Target read data |
| tgt_ready | input | 1 | Target ready for the current request |
| wake_en | input | 1 | Wake output enable |
| frame_rx | input | 1 | Frame received pulse |
| rx_irq_ack | input | 1 | Receive interrupt acknowledge |

## Verification
Some properties are checked on every cycle by assertions:

- At most one target select is active.
- With no card enable, nothing is selected or driven.
- An IO select always comes with a low 16-bit indicator.
- Wait rises the clock after ready.
- Latched read data stays stable in the done state.
- The wake output holds until the acknowledge and ignores frames that are disabled.

Lane steering is shown only by the bench's cycles, which cover random enable, address, space and strobe combinations plus directed cases:

- Byte enables, copied write data and zeroed lanes for each mode.
- Rejection of several strobes at once.
- The exact wait release cycle for each target latency.
- Read data held while the target's data changes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_BYTE = 2'd1,
        LANE_WORD = 2'd2,
        LANE_ODD  = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_ATTR = 2'd1,
        SPC_COMM = 2'd2,
        SPC_IO   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ACCESS = 2'd1,
        CYC_DONE   = 2'd2
    } cyc_state_e;

    typedef enum logic {
        WK_CLEAR = 1'b0,
        WK_SET   = 1'b1
    } wake_state_e;

endpackage

// File: rtl/pcd_lane_decode.sv
module pcd_lane_decode
    import pcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rdata,
    output lane_e             lane,
    output logic [1:0]        be,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic              lane_lo,
    output logic              lane_hi
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] din_lo, din_hi, rd_lo, rd_hi;

    assign din_lo = din[HALF_W-1:0];
    assign din_hi = din[DATA_W-1:HALF_W];
    assign rd_lo  = rdata[HALF_W-1:0];
    assign rd_hi  = rdata[DATA_W-1:HALF_W];

    // Card enables double as lane enables
    always_comb begin
        unique case ({ce1_n, ce2_n})
            2'b01:   lane = LANE_BYTE;
            2'b00:   lane = LANE_WORD;
            2'b10:   lane = LANE_ODD;
            default: lane = LANE_NONE;
        endcase
    end

    always_comb begin
        be      = 2'b00;
        wdata   = '0;
        dout    = '0;
        lane_lo = 1'b0;
        lane_hi = 1'b0;
        unique case (lane)
            LANE_BYTE: begin
                lane_lo = 1'b1;
                be      = a0 ? 2'b10 : 2'b01;
                wdata   = {din_lo, din_lo};
                dout    = {{HALF_W{1'b0}}, (a0 ? rd_hi : rd_lo)};
            end
            LANE_WORD: begin
                lane_lo = 1'b1;
                lane_hi = 1'b1;
                be      = 2'b11;
                wdata   = din;
                dout    = rdata;
            end
            LANE_ODD: begin
                lane_hi = 1'b1;
                be      = 2'b10;
                wdata   = {din_hi, din_hi};
                dout    = {rd_hi, {HALF_W{1'b0}}};
            end
            LANE_NONE: begin
                be = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/pcd_space_decode.sv
module pcd_space_decode
    import pcd_pkg::*;
(
    input  logic   reg_n,
    input  logic   oe_n,
    input  logic   we_n,
    input  logic   iord_n,
    input  logic   iowr_n,
    input  lane_e  lane,
    output space_e space,
    output logic   valid,
    output logic   is_read,
    output logic   io16_n
);
    logic [3:0] strobes;
    logic       one_strobe;
    logic       mem_cyc;
    logic       io_cyc;

    assign strobes    = {~iowr_n, ~iord_n, ~we_n, ~oe_n};
    assign one_strobe = ($countones(strobes) == 1);
    assign mem_cyc    = one_strobe && (strobes[0] || strobes[1]);
    assign io_cyc     = one_strobe && (strobes[2] || strobes[3]);

    always_comb begin
        space = SPC_NONE;
        if (lane != LANE_NONE) begin
            if (mem_cyc) begin
                space = reg_n ? SPC_COMM : SPC_ATTR;
            end else if (io_cyc && !reg_n) begin
                space = SPC_IO;
            end
        end
    end

    assign valid   = (space != SPC_NONE);
    assign is_read = valid && (strobes[0] || strobes[2]);
    // Depends only on the space select and memory strobes: settles before enables
    assign io16_n  = reg_n || !oe_n || !we_n;

endmodule

// File: rtl/pcd_cycle_fsm.sv
module pcd_cycle_fsm
    import pcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              is_read,
    input  logic              tgt_ready,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              req,
    output logic              wait_n,
    output logic              drive,
    output logic [DATA_W-1:0] rdata_q
);
    cyc_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CYC_IDLE;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (state == CYC_ACCESS && valid && tgt_ready && is_read) begin
                rdata_q <= rdata_in;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CYC_IDLE:   if (valid) nxt = CYC_ACCESS;
            CYC_ACCESS: begin
                if (!valid)         nxt = CYC_IDLE;
                else if (tgt_ready) nxt = CYC_DONE;
            end
            CYC_DONE:   if (!valid) nxt = CYC_IDLE;
            default:    nxt = CYC_IDLE;
        endcase
    end

    always_comb begin
        req    = (state == CYC_ACCESS);
        wait_n = !(((state == CYC_IDLE) && valid) || (state == CYC_ACCESS));
        drive  = (state == CYC_DONE) && is_read;
    end

    // R9: wait released the clock after ready
    p_wait_release_r9: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_ACCESS && valid && tgt_ready) |=> wait_n);

    // R10: latched read data holds through the done state
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_DONE && $past(state == CYC_DONE)) |-> $stable(rdata_q));

endmodule

// File: rtl/pcd_wake.sv
module pcd_wake
    import pcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic frame,
    input  logic ack,
    output logic wake_n
);
    wake_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= WK_CLEAR;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WK_CLEAR: if (en && frame) nxt = WK_SET;
            WK_SET:   if (ack)         nxt = WK_CLEAR;
        endcase
    end

    always_comb wake_n = (state != WK_SET);

    // R11: held until acknowledge
    p_wake_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!wake_n && !ack) |=> !wake_n);

    // R11: frames with wake disabled change nothing
    p_wake_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (wake_n && !(en && frame)) |=> wake_n);

endmodule

// File: rtl/pccard_decoder.sv
module pccard_decoder
    import pcd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_ce1_n,
    input  logic              host_ce2_n,
    input  logic [ADDR_W-1:0] host_a,
    input  logic              host_reg_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic              host_iord_n,
    input  logic              host_iowr_n,
    input  logic [DATA_W-1:0] host_d_in,
    output logic [DATA_W-1:0] host_d_out,
    output logic              host_d_oe_lo,
    output logic              host_d_oe_hi,
    output logic              host_io16_n,
    output logic              host_wait_n,
    output logic              host_wake_n,
    output logic              tgt_attr_sel,
    output logic              tgt_comm_sel,
    output logic              tgt_io_sel,
    output logic              tgt_rd,
    output logic              tgt_wr,
    output logic [ADDR_W-2:0] tgt_addr,
    output logic [1:0]        tgt_be,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata,
    input  logic              tgt_ready,
    input  logic              wake_en,
    input  logic              frame_rx,
    input  logic              rx_irq_ack
);
    lane_e             lane;
    space_e            space;
    logic              valid, is_read, req, drive;
    logic              lane_lo, lane_hi;
    logic [DATA_W-1:0] rdata_q;

    pcd_lane_decode #(.DATA_W(DATA_W)) u_lane (
        .ce1_n   (host_ce1_n),
        .ce2_n   (host_ce2_n),
        .a0      (host_a[0]),
        .din     (host_d_in),
        .rdata   (rdata_q),
        .lane    (lane),
        .be      (tgt_be),
        .wdata   (tgt_wdata),
        .dout    (host_d_out),
        .lane_lo (lane_lo),
        .lane_hi (lane_hi)
    );

    pcd_space_decode u_space (
        .reg_n   (host_reg_n),
        .oe_n    (host_oe_n),
        .we_n    (host_we_n),
        .iord_n  (host_iord_n),
        .iowr_n  (host_iowr_n),
        .lane    (lane),
        .space   (space),
        .valid   (valid),
        .is_read (is_read),
        .io16_n  (host_io16_n)
    );

    pcd_cycle_fsm #(.DATA_W(DATA_W)) u_cyc (
        .clk       (clk),
        .rst       (rst),
        .valid     (valid),
        .is_read   (is_read),
        .tgt_ready (tgt_ready),
        .rdata_in  (tgt_rdata),
        .req       (req),
        .wait_n    (host_wait_n),
        .drive     (drive),
        .rdata_q   (rdata_q)
    );

    pcd_wake u_wake (
        .clk    (clk),
        .rst    (rst),
        .en     (wake_en),
        .frame  (frame_rx),
        .ack    (rx_irq_ack),
        .wake_n (host_wake_n)
    );

    assign tgt_addr     = host_a[ADDR_W-1:1];
    assign tgt_attr_sel = req && (space == SPC_ATTR);
    assign tgt_comm_sel = req && (space == SPC_COMM);
    assign tgt_io_sel   = req && (space == SPC_IO);
    assign tgt_rd       = req && valid && is_read;
    assign tgt_wr       = req && valid && !is_read;
    assign host_d_oe_lo = drive && lane_lo;
    assign host_d_oe_hi = drive && lane_hi;

    // R6: selects never overlap
    p_sel_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tgt_attr_sel, tgt_comm_sel, tgt_io_sel}));

    // R1: no card enable means no select and no drive
    p_no_card_r1: assert property (@(posedge clk) disable iff (rst)
        (host_ce1_n && host_ce2_n) |->
            !(tgt_attr_sel || tgt_comm_sel || tgt_io_sel || host_d_oe_lo || host_d_oe_hi));

    // R8: IO register selection always reports 16-bit width
    p_io16_r8: assert property (@(posedge clk) disable iff (rst)
        tgt_io_sel |-> !host_io16_n);

endmodule

// File: tb/pccard_decoder_test.sv
module pccard_decoder_test;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [ADDR_W-1:0] a = '0;
    logic [DATA_W-1:0] d_in = '0, t_rdata = '0;
    logic t_ready = 1'b0, w_en = 1'b0, frame = 1'b0, ack = 1'b0;
    logic [DATA_W-1:0] d_out, t_wdata;
    logic oe_lo, oe_hi, io16_n, wait_n, wake_n;
    logic s_attr, s_comm, s_io, t_rd, t_wr;
    logic [ADDR_W-2:0] t_addr;
    logic [1:0] t_be;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pccard_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .host_ce1_n(ce1_n), .host_ce2_n(ce2_n),
        .host_a(a), .host_reg_n(reg_n), .host_oe_n(oe_n), .host_we_n(we_n),
        .host_iord_n(iord_n), .host_iowr_n(iowr_n), .host_d_in(d_in),
        .host_d_out(d_out), .host_d_oe_lo(oe_lo), .host_d_oe_hi(oe_hi),
        .host_io16_n(io16_n), .host_wait_n(wait_n), .host_wake_n(wake_n),
        .tgt_attr_sel(s_attr), .tgt_comm_sel(s_comm), .tgt_io_sel(s_io),
        .tgt_rd(t_rd), .tgt_wr(t_wr), .tgt_addr(t_addr), .tgt_be(t_be),
        .tgt_wdata(t_wdata), .tgt_rdata(t_rdata), .tgt_ready(t_ready),
        .wake_en(w_en), .frame_rx(frame), .rx_irq_ack(rx_irq_ack_w)
    );
    logic rx_irq_ack_w;
    assign rx_irq_ack_w = ack;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected-value functions, from the requirements
    function automatic logic [1:0] f_be(logic c1, logic c2, logic a0);
        if (!c1 && c2)  return a0 ? 2'b10 : 2'b01;
        if (!c1 && !c2) return 2'b11;
        if (c1 && !c2)  return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [15:0] f_wdata(logic c1, logic c2, logic [15:0] d);
        if (!c1 && c2)  return {d[7:0], d[7:0]};
        if (c1 && !c2)  return {d[15:8], d[15:8]};
        return d;
    endfunction

    function automatic logic [15:0] f_dout(logic c1, logic c2, logic a0, logic [15:0] r);
        if (!c1 && c2)  return {8'h00, (a0 ? r[15:8] : r[7:0])};
        if (c1 && !c2)  return {r[15:8], 8'h00};
        return r;
    endfunction

    // kind: 0 mem read, 1 mem write, 2 io read, 3 io write; returns {io,comm,attr}
    function automatic logic [2:0] f_sel(logic c1, logic c2, logic rg, int kind, bit extra);
        if ((c1 && c2) || extra) return 3'b000;
        if (kind < 2) return rg ? 3'b010 : 3'b001;
        return rg ? 3'b000 : 3'b100;
    endfunction

    task automatic set_strobes(input int kind, input bit extra);
        oe_n   = !(kind == 0);
        we_n   = !(kind == 1);
        iord_n = !(kind == 2);
        iowr_n = !(kind == 3);
        if (extra) begin
            if (kind == 0) we_n = 1'b0;
            else           oe_n = 1'b0;
        end
    endtask

    task automatic release_strobes();
        oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
    endtask

    task automatic run_cycle(input logic c1, input logic c2, input logic [ADDR_W-1:0] ad,
                             input logic rg, input int kind, input bit extra,
                             input logic [15:0] wd, input logic [15:0] rd, input int lat);
        logic [2:0] es;
        bit rdk;
        es  = f_sel(c1, c2, rg, kind, extra);
        rdk = (kind == 0 || kind == 2);
        @(negedge clk);
        ce1_n = c1; ce2_n = c2; a = ad; reg_n = rg; d_in = wd;
        release_strobes();
        #1;
        chk(io16_n == rg, "R8 io16 before strobe", io16_n, rg);
        set_strobes(kind, extra);
        #1;
        chk(wait_n == (es == 3'b000), "R9 wait at cycle start", wait_n, es == 3'b000);
        if (es == 3'b000) begin
            repeat (2) begin
                @(negedge clk);
                chk({s_io, s_comm, s_attr, oe_lo, oe_hi, t_rd, t_wr} == 7'b0,
                    "R1/R6/R7 no access", {s_io, s_comm, s_attr, oe_lo, oe_hi}, 0);
                chk(wait_n == 1'b1, "R1 no wait", wait_n, 1);
            end
            release_strobes();
            return;
        end
        for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            chk({s_io, s_comm, s_attr} == es, "R5/R6 select", {s_io, s_comm, s_attr}, es);
            chk(t_be == f_be(c1, c2, ad[0]), "R2/R3/R4 byte enables", t_be, f_be(c1, c2, ad[0]));
            chk(t_addr == ad[ADDR_W-1:1], "R6 word address", t_addr, ad[ADDR_W-1:1]);
            chk({t_rd, t_wr} == {rdk, !rdk}, "R5 request kind", {t_rd, t_wr}, {rdk, !rdk});
            chk(wait_n == 1'b0, "R9 wait held", wait_n, 0);
            if (!rdk)
                chk(t_wdata == f_wdata(c1, c2, wd), "R2/R3/R4 write data", t_wdata,
                    f_wdata(c1, c2, wd));
        end
        t_ready = 1'b1; t_rdata = rd;
        @(negedge clk);
        t_ready = 1'b0; t_rdata = ~rd;
        chk(wait_n == 1'b1, "R9 wait released", wait_n, 1);
        chk({s_io, s_comm, s_attr} == 3'b000, "R6 select ends", {s_io, s_comm, s_attr}, 0);
        if (rdk) begin
            chk(d_out == f_dout(c1, c2, ad[0], rd), "R2/R3/R4 read lanes", d_out,
                f_dout(c1, c2, ad[0], rd));
            chk({oe_lo, oe_hi} == {!c1, !c2}, "R2/R3/R4 drive lanes", {oe_lo, oe_hi}, {!c1, !c2});
            @(negedge clk);
            chk(d_out == f_dout(c1, c2, ad[0], rd), "R10 read data held", d_out,
                f_dout(c1, c2, ad[0], rd));
        end
        release_strobes();
        #1;
        chk({oe_lo, oe_hi} == 2'b00, "R10 drive stops on release", {oe_lo, oe_hi}, 0);
        @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(wait_n && wake_n && !oe_lo && !oe_hi && !s_attr && !s_comm && !s_io,
            "R7 reset state", {wait_n, wake_n, oe_lo, oe_hi}, 4'b1100);
        rst = 1'b0;
        @(negedge clk);

        // Directed corner cases
        run_cycle(1'b0, 1'b1, 10'h004, 1'b0, 0, 1'b0, 16'h0, 16'hA55A, 0); // R2 even byte
        run_cycle(1'b0, 1'b1, 10'h005, 1'b1, 0, 1'b0, 16'h0, 16'hA55A, 2); // R2 odd byte
        run_cycle(1'b0, 1'b0, 10'h013, 1'b1, 1, 1'b0, 16'hBEEF, 16'h0, 1); // R3 a0 ignored
        run_cycle(1'b1, 1'b0, 10'h020, 1'b0, 2, 1'b0, 16'h0, 16'hC3D4, 3); // R4 odd only
        run_cycle(1'b1, 1'b0, 10'h021, 1'b0, 3, 1'b0, 16'h7E11, 16'h0, 0); // R4 write
        run_cycle(1'b0, 1'b0, 10'h030, 1'b1, 2, 1'b0, 16'h0, 16'h1111, 0); // R6 IO with select high
        run_cycle(1'b0, 1'b0, 10'h030, 1'b0, 0, 1'b1, 16'h0, 16'h2222, 0); // R7 two strobes
        run_cycle(1'b1, 1'b1, 10'h040, 1'b0, 0, 1'b0, 16'h0, 16'h3333, 0); // R1 no card

        // R8: memory strobe lifts the indicator
        @(negedge clk);
        reg_n = 1'b0; oe_n = 1'b0; #1;
        chk(io16_n == 1'b1, "R8 memory strobe", io16_n, 1);
        release_strobes(); #1;
        chk(io16_n == 1'b0, "R8 select low idle", io16_n, 0);

        // R11: wake latch
        @(negedge clk); w_en = 1'b0; frame = 1'b1;
        @(negedge clk); frame = 1'b0;
        chk(wake_n == 1'b1, "R11 disabled frame ignored", wake_n, 1);
        w_en = 1'b1; frame = 1'b1;
        @(negedge clk); frame = 1'b0;
        chk(wake_n == 1'b0, "R11 wake set", wake_n, 0);
        repeat (3) @(negedge clk);
        chk(wake_n == 1'b0, "R11 wake held", wake_n, 0);
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk(wake_n == 1'b1, "R11 wake cleared by ack", wake_n, 1);

        // Random cycles
        for (int n = 0; n < 300; n++) begin
            logic c1, c2, rg;
            int kind, lat;
            bit extra;
            c1 = 1'($urandom); c2 = 1'($urandom); rg = 1'($urandom);
            kind = $urandom % 4; lat = $urandom % 4;
            extra = (($urandom % 8) == 0);
            run_cycle(c1, c2, ADDR_W'($urandom), rg, kind, extra,
                      16'($urandom), 16'($urandom), lat);
        end

        // R7: reset mid-wake
        @(negedge clk); frame = 1'b1;
        @(negedge clk); frame = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(wake_n == 1'b1, "R7 reset clears wake", wake_n, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule